// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host-side master for a 10-bit serial analog-to-digital converter. It drives the converter's active-low chip select and a serial clock that idles low. The serial clock comes from the system clock through a programmable divider. The block takes one data bit on every falling serial-clock edge. A conversion frame begins with six zero bits and then carries the result, most significant bit first.

A host asks for a read with a single-cycle `start` while `ready` is high. The host chooses a read type at the same time. A full read sends 16 clocks in one burst. A split read sends two bursts of 8 clocks and keeps chip select low between them. After the first burst the block raises `paused` and waits for the host to pulse `resume`. A pause longer than a parameterised number of system cycles aborts the frame with an error. A short read sends 6 plus N clocks and then raises chip select, which gives an N-bit result aligned to the right of the output.

Each frame ends with a one-cycle `valid` strobe. The result and the error flag appear in the same cycle as the strobe. The error flag is set when any of the six leading bits was captured as 1, or when the gap watchdog aborted the frame. Before the next frame may start, chip select stays high for at least a parameterised number of cycles.

Top module: `serial_adc_reader`

## Requirements
- R1: After reset `csN` is 1, `sclk` is 0, `valid` is 0 and `ready` is 1. While `csN` is high, `sclk` is always 0.
- R2: A full read (`mode` 2'b00, and also 2'b11) gives exactly 16 rising `sclk` edges while `csN` is low. Every high phase of `sclk` lasts `CLK_DIV` system cycles.
- R3: The bit present on `sdo` is taken at each falling `sclk` edge. In a 16-clock frame, captured bits 7 to 16 form `result[9:0]`, with the MSB first.
- R4: A split read (`mode` 2'b01) stops after 8 clocks. During the stop `csN` stays low, `sclk` stays low and `paused` is 1. A `resume` pulse during the stop sends the remaining 8 clocks.
- R5: If no `resume` arrives within `GAP_LIMIT` system cycles of entering the stop, the frame is aborted. `csN` rises, and `valid` reports `error`=1 with `result`=0.
- R6: A short read (`mode` 2'b10) sends 6+N clocks and then raises `csN`. N is `resSel`, with 0 treated as 1 and values above 10 treated as 10. The N data bits sit in `result[N-1:0]` and the upper bits are 0.
- R7: `error` is 1 exactly when one of the six leading captured bits was 1 or the frame was aborted.
- R8: Between two frames `csN` stays high for at least `CS_HIGH_MIN` cycles. `ready` is 0 in the cycle `valid` is high.
- R9: `valid` is high for a single cycle per frame. A `start` while `ready` is 0 has no effect. A `resume` outside a stop has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Read request, taken only while ready is high |
| mode | input | 2 | Read type: 00 full, 01 split, 10 short, 11 full |
| resSel | input | 4 | Result width for short reads (clamped to 1..10) |
| resume | input | 1 | Continue a split read after its stop |
| sdo | input | 1 | Serial data from the converter |
| csN | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles low |
| ready | output | 1 | Block idle and chip-select high time served |
| paused | output | 1 | Split read is waiting for resume |
| result | output | 10 | Right-aligned conversion result |
| valid | output | 1 | One-cycle strobe: result and error are valid |
| error | output | 1 | Leading bit was 1, or the frame was aborted |

## Verification
Assertions check the following on every cycle:
- `sclk` stays low while chip select is high, and stays quiet during a stop.
- The stop never outlasts the gap limit.
- The bit count never passes the frame length.
- The chip-select high time before each frame is at least `CS_HIGH_MIN`.
- `valid` is a single pulse, and an abort produces a zero result with the error flag set.

Other behaviour can only be shown by the bench's scenarios. These are the clock count for each read type, the clamping of `resSel`, and whether the captured bits land in the right result positions. They also include the effect of `resume` timing just inside the limit, and whether stray `start` or `resume` pulses are ignored.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
  localparam int LEAD_BITS = 6;
  localparam int RES_MAX   = 10;
  localparam int FRAME_MAX = LEAD_BITS + RES_MAX;
  localparam int SPLIT_AT  = 8;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  typedef enum logic [1:0] {
    MODE_FULL  = 2'b00,
    MODE_SPLIT = 2'b01,
    MODE_SHORT = 2'b10,
    MODE_ALT   = 2'b11
  } rdMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic clear;
    logic shift;
    logic load;
    logic abort;
  } dpStrobe_t;
endpackage

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
  import adcrd_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int GAP_LIMIT   = 1000,
  parameter int CS_HIGH_MIN = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] mode,
  input  logic [3:0] resSel,
  input  logic       resume,
  output logic       csN,
  output logic       sclk,
  output logic       ready,
  output logic       paused,
  output logic [3:0] resW,
  output dpStrobe_t  stb
);
  localparam int DIV_W  = $clog2(CLK_DIV + 1);
  localparam int GAP_W  = $clog2(GAP_LIMIT + 1);
  localparam int HOLD_W = $clog2(CS_HIGH_MIN + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_HIGH, S_PAUSE, S_DONE} state_e;

  state_e             state;
  logic [DIV_W-1:0]   divCnt;
  logic [CNT_W-1:0]   bitCnt;
  logic [CNT_W-1:0]   frameLen;
  logic [GAP_W-1:0]   gapCnt;
  logic [HOLD_W-1:0]  holdCnt;
  logic [3:0]         resQ;
  logic               splitQ;
  logic               abortQ;
  logic               csNQ;
  logic               sclkQ;

  logic               divLast;
  logic               holdDone;
  logic [CNT_W-1:0]   bitNext;

  function automatic logic [3:0] clampRes(input logic [3:0] r);
    if (r == 4'd0) return 4'd1;
    else if (r > 4'(RES_MAX)) return 4'(RES_MAX);
    else return r;
  endfunction

  assign divLast  = (divCnt == DIV_W'(CLK_DIV - 1));
  assign holdDone = (holdCnt >= HOLD_W'(CS_HIGH_MIN));
  assign bitNext  = bitCnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      divCnt   <= '0;
      bitCnt   <= '0;
      frameLen <= CNT_W'(FRAME_MAX);
      gapCnt   <= '0;
      holdCnt  <= HOLD_W'(CS_HIGH_MIN);
      resQ     <= 4'(RES_MAX);
      splitQ   <= 1'b0;
      abortQ   <= 1'b0;
      csNQ     <= 1'b1;
      sclkQ    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (!holdDone) holdCnt <= holdCnt + HOLD_W'(1);
          if (start && holdDone) begin
            state  <= S_LOW;
            csNQ   <= 1'b0;
            divCnt <= '0;
            bitCnt <= '0;
            abortQ <= 1'b0;
            splitQ <= (mode == MODE_SPLIT);
            if (mode == MODE_SHORT) begin
              resQ     <= clampRes(resSel);
              frameLen <= CNT_W'(LEAD_BITS) + CNT_W'(clampRes(resSel));
            end else begin
              resQ     <= 4'(RES_MAX);
              frameLen <= CNT_W'(FRAME_MAX);
            end
          end
        end
        S_LOW: begin
          if (divLast) begin
            sclkQ  <= 1'b1;
            divCnt <= '0;
            state  <= S_HIGH;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        S_HIGH: begin
          if (divLast) begin
            sclkQ  <= 1'b0;
            divCnt <= '0;
            bitCnt <= bitNext;
            if (bitNext == frameLen) begin
              state <= S_DONE;
              csNQ  <= 1'b1;
            end else if (splitQ && bitNext == CNT_W'(SPLIT_AT)) begin
              state  <= S_PAUSE;
              gapCnt <= '0;
            end else begin
              state <= S_LOW;
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        S_PAUSE: begin
          if (resume) begin
            state  <= S_LOW;
            divCnt <= '0;
          end else if (gapCnt == GAP_W'(GAP_LIMIT - 1)) begin
            state  <= S_DONE;
            csNQ   <= 1'b1;
            abortQ <= 1'b1;
          end else begin
            gapCnt <= gapCnt + GAP_W'(1);
          end
        end
        S_DONE: begin
          state   <= S_IDLE;
          holdCnt <= '0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign csN    = csNQ;
  assign sclk   = sclkQ;
  assign ready  = (state == S_IDLE) && holdDone;
  assign paused = (state == S_PAUSE);
  assign resW   = resQ;

  always_comb begin
    stb.clear = (state == S_IDLE) && start && holdDone;
    stb.shift = (state == S_HIGH) && divLast;
    stb.load  = (state == S_DONE);
    stb.abort = abortQ;
  end

  // checker-only: run length of chip-select high, saturating
  logic [HOLD_W:0] highRun;
  always_ff @(posedge clk) begin
    if (!rstN) highRun <= '1;
    else if (csNQ) begin
      if (highRun != '1) highRun <= highRun + 1'b1;
    end else highRun <= '0;
  end

  p_sclk_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    csNQ |-> !sclkQ);
  p_frame_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= frameLen);
  p_pause_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PAUSE) |-> (!sclkQ && !csNQ));
  p_gap_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PAUSE) |-> (gapCnt < GAP_W'(GAP_LIMIT)));
  p_cs_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csNQ) |-> (highRun >= (HOLD_W+1)'(CS_HIGH_MIN)));
endmodule

// File: rtl/adcrd_dp.sv
module adcrd_dp
  import adcrd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          stb,
  input  logic               sdo,
  input  logic [3:0]         resW,
  output logic [RES_MAX-1:0] result,
  output logic               error,
  output logic               valid
);
  logic [FRAME_MAX-1:0] shiftReg;
  logic [CNT_W-1:0]     capCnt;
  logic                 leadErr;
  logic [RES_MAX-1:0]   resMask;
  logic [RES_MAX-1:0]   resultQ;
  logic                 errorQ;
  logic                 validQ;

  assign resMask = ~({RES_MAX{1'b1}} << resW);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      capCnt   <= '0;
      leadErr  <= 1'b0;
      resultQ  <= '0;
      errorQ   <= 1'b0;
      validQ   <= 1'b0;
    end else begin
      validQ <= stb.load;
      if (stb.clear) begin
        shiftReg <= '0;
        capCnt   <= '0;
        leadErr  <= 1'b0;
      end else if (stb.shift) begin
        shiftReg <= {shiftReg[FRAME_MAX-2:0], sdo};
        capCnt   <= capCnt + CNT_W'(1);
        if (capCnt < CNT_W'(LEAD_BITS)) leadErr <= leadErr | sdo;
      end
      if (stb.load) begin
        resultQ <= stb.abort ? '0 : (shiftReg[RES_MAX-1:0] & resMask);
        errorQ  <= leadErr | stb.abort;
      end
    end
  end

  assign result = resultQ;
  assign error  = errorQ;
  assign valid  = validQ;

  p_abort_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.abort) |=> (result == '0 && error));
  p_lead_err_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && leadErr) |=> error);
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> !valid);
endmodule

// File: rtl/serial_adc_reader.sv
module serial_adc_reader
  import adcrd_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int GAP_LIMIT   = 1000,
  parameter int CS_HIGH_MIN = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [1:0]  mode,
  input  logic [3:0]  resSel,
  input  logic        resume,
  input  logic        sdo,
  output logic        csN,
  output logic        sclk,
  output logic        ready,
  output logic        paused,
  output logic [9:0]  result,
  output logic        valid,
  output logic        error
);
  dpStrobe_t  stb;
  logic [3:0] resW;

  adcrd_ctrl #(
    .CLK_DIV(CLK_DIV), .GAP_LIMIT(GAP_LIMIT), .CS_HIGH_MIN(CS_HIGH_MIN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .resSel(resSel),
    .resume(resume), .csN(csN), .sclk(sclk), .ready(ready),
    .paused(paused), .resW(resW), .stb(stb)
  );

  adcrd_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdo(sdo), .resW(resW),
    .result(result), .error(error), .valid(valid)
  );
endmodule

// File: tb/sim_serial_adc_reader.sv
`timescale 1ns/1ps
module sim_serial_adc_reader;
  localparam int DIV = 2, GAP = 20, CSMIN = 4;

  logic clk = 0, rstN = 0, start = 0, resume = 0, sdo = 0;
  logic [1:0] mode = 0;
  logic [3:0] resSel = 0;
  logic csN, sclk, ready, paused, valid, error;
  logic [9:0] result;

  serial_adc_reader #(.CLK_DIV(DIV), .GAP_LIMIT(GAP), .CS_HIGH_MIN(CSMIN)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .resSel(resSel),
    .resume(resume), .sdo(sdo), .csN(csN), .sclk(sclk), .ready(ready),
    .paused(paused), .result(result), .valid(valid), .error(error));

  always #2.5 clk = ~clk;

  int nChk = 0, nFail = 0;
  logic [15:0] word = 0;
  int idx = 0, rises = 0;
  int highRun = 1000, lastRun = 1000, hiLen = 0, badPhase = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int clampR(input int r);
    if (r == 0) return 1;
    if (r > 10) return 10;
    return r;
  endfunction

  function automatic int expLen(input int m, input int r);
    return (m == 2) ? 6 + clampR(r) : 16;
  endfunction

  function automatic int expRes(input logic [15:0] w, input int len);
    int n = len - 6;
    return (int'(w) >> (16 - len)) & ((1 << n) - 1);
  endfunction

  // converter model: new bit on each rising sclk, frame restarts on csN fall
  initial forever begin
    @(posedge sclk or negedge csN);
    if (!csN && sclk) begin
      sdo = (idx < 16) ? word[15 - idx] : 1'b0;
      idx++;
      rises++;
    end else if (!csN) begin
      idx = 0; rises = 0; sdo = 0;
    end
  end

  // monitor: chip-select high runs and sclk high-phase length
  initial forever begin
    @(negedge clk);
    if (csN) highRun++;
    else begin
      if (highRun > 0) lastRun = highRun;
      highRun = 0;
    end
    if (sclk) hiLen++;
    else begin
      if (hiLen != 0 && hiLen != DIV) badPhase++;
      hiLen = 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFail++; nChk++;
    $display("FAIL R1 watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  task automatic runFrame(input logic [1:0] m, input logic [3:0] r,
                          input logic [15:0] w, input int gapWait,
                          input bit midStart);
    int t, len;
    bit abort;
    abort = (m == 2'b01) && (gapWait < 0);
    @(negedge clk);
    mode = m; resSel = r; word = w;
    t = 0;
    while (!ready && t < 1000) begin @(negedge clk); t++; end
    start = 1; @(negedge clk); start = 0;
    t = 0;
    while (csN && t < 50) begin @(negedge clk); t++; end
    check(lastRun >= CSMIN, "R8", "cs high run", lastRun, CSMIN);
    if (midStart) begin
      repeat (5) @(negedge clk);
      start = 1; resume = 1; @(negedge clk); start = 0; resume = 0;
    end
    if (m == 2'b01) begin
      t = 0;
      while (!paused && t < 1000) begin @(negedge clk); t++; end
      check(paused && rises == 8 && !csN && !sclk, "R4", "clocks at stop",
            rises, 8);
      if (gapWait >= 0) begin
        repeat (gapWait) @(negedge clk);
        resume = 1; @(negedge clk); resume = 0;
      end
    end
    t = 0;
    while (!valid && t < 1000) begin @(negedge clk); t++; end
    len = abort ? 8 : expLen(int'(m), int'(r));
    check(valid, "R9", "valid seen", int'(valid), 1);
    check(rises == len, (m == 2'b10) ? "R6" : "R2", "rising edges", rises, len);
    check(!ready, "R8", "ready with valid", int'(ready), 0);
    if (abort) begin
      check(result == 0 && error && csN, "R5", "abort result/error",
            int'(result), 0);
    end else begin
      check(int'(result) == expRes(w, len), (m == 2'b10) ? "R6" : "R3",
            "result", int'(result), expRes(w, len));
      check(error == (|w[15:10]), "R7", "lead error", int'(error),
            int'(|w[15:10]));
    end
    @(negedge clk);
    check(!valid, "R9", "valid one cycle", int'(valid), 0);
    if (midStart) begin
      repeat (CSMIN + 20) @(negedge clk);
      check(csN && !valid, "R9", "start while busy ignored", int'(csN), 1);
    end
  endtask

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(csN && !sclk && !valid && ready, "R1", "reset state",
          int'({csN, sclk, valid, ready}), 9);
    // directed corners
    runFrame(2'b00, 4'd0, 16'h03FF, 0, 1'b0);
    runFrame(2'b00, 4'd0, 16'h8155, 0, 1'b0);   // lead bit set, R7
    runFrame(2'b11, 4'd0, 16'h0155, 0, 1'b1);   // alt full, stray start/resume
    runFrame(2'b10, 4'd8, 16'h02A7, 0, 1'b0);   // 14 clocks, 8-bit result
    runFrame(2'b10, 4'd0, 16'h0200, 0, 1'b0);   // clamp to 1
    runFrame(2'b10, 4'd15, 16'h0333, 0, 1'b0);  // clamp to 10
    runFrame(2'b10, 4'd3, 16'h0400, 0, 1'b0);   // error in short frame
    runFrame(2'b01, 4'd0, 16'h01C3, 0, 1'b0);
    runFrame(2'b01, 4'd0, 16'h0299, GAP - 2, 1'b0); // resume near limit
    runFrame(2'b01, 4'd0, 16'h03FF, -1, 1'b0);  // gap abort, R5
    // random frames
    for (int i = 0; i < 40; i++) begin
      logic [1:0] m; logic [3:0] r; logic [15:0] w; int g;
      m = 2'($urandom % 4);
      r = 4'($urandom % 16);
      w = 16'($urandom);
      if ($urandom % 3 != 0) w[15:10] = 6'd0;
      g = ($urandom % 8 == 0) ? -1 : int'($urandom % (GAP - 1));
      runFrame(m, r, w, g, 1'b0);
    end
    check(badPhase == 0, "R2", "sclk high phase length", badPhase, 0);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule